// File: doc/BRIEF.md
# Transmitter Analog Power-Up Sequencer

This block brings the analog support circuits of a display transmitter out of power-down in a fixed order. The hardware sequencer normally in charge of this cannot be used, so the block takes over: on a start strobe it picks the link-rate code for the selected mode and asserts every power-down control. It then releases them one group at a time, with a timed settle after each group. Time is measured in pulses of a free-running 1 µs tick, so every wait is a count of ticks.

Between the first and second groups the block takes the I/O pads out of deep power-down. It lowers the pad deep-power-down control and then samples a busy acknowledge from the pads once per poll interval. It moves on at the first sample that shows the pads awake. If the pads are still busy after the poll budget runs out, it sets a sticky error flag and continues the sequence anyway.

The states are IDLE (everything asserted, waiting for start), ARM (step one: all controls asserted, rate latched), IO_POLL (pad control released, polling the acknowledge), IO_SETTLE (fixed settle after the pads wake), BGAP_SETTLE (bandgap released), PLL_SETTLE (PLL, VCO and loop-capacitor controls released) and READY (port released, ready flag high). The transitions are:

- IDLE→ARM on start while not ready.
- ARM→IO_POLL after one cycle.
- IO_POLL→IO_SETTLE on a poll that sees the pads awake, or on poll exhaustion.
- IO_POLL→IO_POLL on a busy poll that is within budget.
- IO_SETTLE→BGAP_SETTLE, BGAP_SETTLE→PLL_SETTLE and PLL_SETTLE→READY each when its wait expires.

Only reset leaves READY.

Top module: `txpwr_seq`

## Requirements
- R1: After reset all seven power-down outputs are 1. The ready flag and the error flag are 0, and the rate output holds RATE_DP_LOW (default 8'h06).
- R2: A start accepted in IDLE latches the rate output in the same edge. It takes RATE_LVDS (default 8'h00) when lvds_sel_i is 1 and RATE_DP_LOW otherwise. The rate then stays unchanged until reset, whatever lvds_sel_i does.
- R3: In the cycle after an accepted start, all seven controls are 1. One cycle later io_dpd_o drops to 0 and the other six stay 1.
- R4: While polling, dpd_busy_i is sampled on every POLL_US-th tick. The first sample that is 0 moves the block to the I/O settle wait.
- R5: When POLL_MAX_US/POLL_US consecutive samples are 1, dpd_err_o goes to 1 and stays there until reset. The sequence then continues as if the pads had answered.
- R6: T_IO_US ticks into the I/O settle wait, bgap_pd_o drops to 0.
- R7: T_BG_US ticks into the bandgap wait, pll_pd_o, vco_pd_o and loopcap_pd_o drop to 0 on the same edge.
- R8: T_PLL_US ticks into the PLL wait, port_pd_o drops to 0 and pwr_ready_o rises.
- R9: cal_pd_o is 1 at all times.
- R10: Start is ignored while a sequence runs or once ready: the rate, controls and flags are unaffected. Ticks in IDLE change nothing.
- R11: pwr_ready_o and the released controls stay in place until reset. Reset returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request strobe |
| lvds_sel_i | input | 1 | 1 selects LVDS mode, 0 selects DP |
| tick_us_i | input | 1 | One-cycle pulse every microsecond |
| dpd_busy_i | input | 1 | Pad acknowledge, 1 while still in deep power-down |
| port_pd_o | output | 1 | Port power-down, active high |
| pll_pd_o | output | 1 | PLL power-down, active high |
| bgap_pd_o | output | 1 | Bandgap power-down, active high |
| vco_pd_o | output | 1 | VCO power-down, active high |
| loopcap_pd_o | output | 1 | Loop-capacitor power-down, active high |
| io_dpd_o | output | 1 | Pad deep-power-down control, active high |
| cal_pd_o | output | 1 | Pad calibration power-down, active high |
| link_rate_o | output | RATE_W | Link-rate code |
| pwr_ready_o | output | 1 | Power-up complete |
| dpd_err_o | output | 1 | Pad acknowledge timed out |

## Verification
The bench varies when the pads answer: on the very first poll, after a few busy polls, and never. A design that mis-counts the poll budget would raise the error one poll early or late, or would stall the whole sequence. Ticks are spread over random gaps, and stray ticks arrive in IDLE. A timer that counts cycles, or counts the tick that shares an edge with a reload, would release a group early. Start pulses and mode flips during the run and after READY would expose a design that restarts the sequence or re-latches the rate.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ARM,
        SQ_IO_POLL,
        SQ_IO_SETTLE,
        SQ_BGAP_SETTLE,
        SQ_PLL_SETTLE,
        SQ_READY
    } sq_state_e;

    // Active-high power-down controls
    typedef struct packed {
        logic port;
        logic pll;
        logic bgap;
        logic vco;
        logic cap;
        logic io;
        logic cal;
    } pd_ctrl_t;

endpackage

// File: rtl/pwrseq_tick_timer.sv
module pwrseq_tick_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    // Load wins over counting; a tick in the load cycle is not counted.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expire_o = tick_i && (cnt_q == W'(1));

    // R4: every wait is at least one tick long
    p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (load_val_i != '0));

    // R6: the counter only moves by one tick at a time
    p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q));

endmodule

// File: rtl/pwrseq_step_decode.sv
module pwrseq_step_decode
    import pwrseq_pkg::*;
(
    input  sq_state_e state_i,
    output pd_ctrl_t  ctrl_o
);
    always_comb begin
        ctrl_o = '{port: 1'b1, pll: 1'b1, bgap: 1'b1, vco: 1'b1,
                   cap: 1'b1, io: 1'b1, cal: 1'b1};
        unique case (state_i)
            SQ_IDLE, SQ_ARM: ;
            SQ_IO_POLL, SQ_IO_SETTLE: ctrl_o.io = 1'b0;
            SQ_BGAP_SETTLE: begin
                ctrl_o.io   = 1'b0;
                ctrl_o.bgap = 1'b0;
            end
            SQ_PLL_SETTLE: begin
                ctrl_o.io   = 1'b0;
                ctrl_o.bgap = 1'b0;
                ctrl_o.pll  = 1'b0;
                ctrl_o.vco  = 1'b0;
                ctrl_o.cap  = 1'b0;
            end
            SQ_READY: begin
                ctrl_o.io   = 1'b0;
                ctrl_o.bgap = 1'b0;
                ctrl_o.pll  = 1'b0;
                ctrl_o.vco  = 1'b0;
                ctrl_o.cap  = 1'b0;
                ctrl_o.port = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/txpwr_seq.sv
module txpwr_seq
    import pwrseq_pkg::*;
#(
    parameter int              T_IO_US     = 15,
    parameter int              T_BG_US     = 25,
    parameter int              T_PLL_US    = 225,
    parameter int              POLL_US     = 20,
    parameter int              POLL_MAX_US = 10000,
    parameter int              RATE_W      = 8,
    parameter logic [RATE_W-1:0] RATE_LVDS   = 8'h00,
    parameter logic [RATE_W-1:0] RATE_DP_LOW = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              lvds_sel_i,
    input  logic              tick_us_i,
    input  logic              dpd_busy_i,
    output logic              port_pd_o,
    output logic              pll_pd_o,
    output logic              bgap_pd_o,
    output logic              vco_pd_o,
    output logic              loopcap_pd_o,
    output logic              io_dpd_o,
    output logic              cal_pd_o,
    output logic [RATE_W-1:0] link_rate_o,
    output logic              pwr_ready_o,
    output logic              dpd_err_o
);
    localparam int N_POLL   = (POLL_MAX_US / POLL_US < 1) ? 1 : POLL_MAX_US / POLL_US;
    localparam int MAX_A    = (T_IO_US > T_BG_US) ? T_IO_US : T_BG_US;
    localparam int MAX_B    = (T_PLL_US > POLL_US) ? T_PLL_US : POLL_US;
    localparam int MAX_WAIT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W    = $clog2(MAX_WAIT + 1);
    localparam int PC_W     = $clog2(N_POLL + 1);

    sq_state_e         state_q, state_d;
    logic              tmr_load;
    logic [TMR_W-1:0]  tmr_val;
    logic              expire;
    logic [PC_W-1:0]   poll_q;
    logic              poll_inc, err_set, rate_load;
    logic              err_q;
    logic [RATE_W-1:0] rate_q;
    pd_ctrl_t          ctrl;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // Next state and wait loading
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        poll_inc  = 1'b0;
        err_set   = 1'b0;
        rate_load = 1'b0;
        unique case (state_q)
            SQ_IDLE: if (start_i) begin
                state_d   = SQ_ARM;
                rate_load = 1'b1;
            end
            SQ_ARM: begin
                state_d  = SQ_IO_POLL;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(POLL_US);
            end
            SQ_IO_POLL: if (expire) begin
                tmr_load = 1'b1;
                if (!dpd_busy_i) begin
                    state_d = SQ_IO_SETTLE;
                    tmr_val = TMR_W'(T_IO_US);
                end else if (poll_q == PC_W'(N_POLL - 1)) begin
                    err_set = 1'b1;
                    state_d = SQ_IO_SETTLE;
                    tmr_val = TMR_W'(T_IO_US);
                end else begin
                    poll_inc = 1'b1;
                    tmr_val  = TMR_W'(POLL_US);
                end
            end
            SQ_IO_SETTLE: if (expire) begin
                state_d  = SQ_BGAP_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_BG_US);
            end
            SQ_BGAP_SETTLE: if (expire) begin
                state_d  = SQ_PLL_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(T_PLL_US);
            end
            SQ_PLL_SETTLE: if (expire) state_d = SQ_READY;
            SQ_READY: ;
            default: state_d = SQ_IDLE;
        endcase
    end

    // Poll budget, error flag and latched rate
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_q <= '0;
            err_q  <= 1'b0;
            rate_q <= RATE_DP_LOW;
        end else begin
            if (poll_inc)  poll_q <= poll_q + 1'b1;
            if (err_set)   err_q  <= 1'b1;
            if (rate_load) rate_q <= lvds_sel_i ? RATE_LVDS : RATE_DP_LOW;
        end
    end

    pwrseq_tick_timer #(.W(TMR_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (tick_us_i),
        .expire_o   (expire)
    );

    pwrseq_step_decode u_decode (
        .state_i (state_q),
        .ctrl_o  (ctrl)
    );

    // Output process
    always_comb begin
        port_pd_o    = ctrl.port;
        pll_pd_o     = ctrl.pll;
        bgap_pd_o    = ctrl.bgap;
        vco_pd_o     = ctrl.vco;
        loopcap_pd_o = ctrl.cap;
        io_dpd_o     = ctrl.io;
        cal_pd_o     = ctrl.cal;
        link_rate_o  = rate_q;
        pwr_ready_o  = (state_q == SQ_READY);
        dpd_err_o    = err_q;
    end

    p_rate_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != SQ_IDLE) |=> $stable(link_rate_o));

    p_err_from_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dpd_err_o) |-> $past(dpd_busy_i));

    p_poll_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        poll_q < PC_W'(N_POLL));

    p_bgap_after_io_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !bgap_pd_o |-> !io_dpd_o);

    p_pll_group_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_pd_o == vco_pd_o) && (vco_pd_o == loopcap_pd_o) && (!pll_pd_o -> !bgap_pd_o));

    p_port_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !port_pd_o |-> (!pll_pd_o && pwr_ready_o));

    p_cal_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ready_o |-> cal_pd_o);

    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_ready_o && start_i) |=> (pwr_ready_o && $stable(link_rate_o)));

    p_ready_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_ready_o |=> (pwr_ready_o && !port_pd_o));

endmodule

// File: tb/txpwr_seq_tb.sv
module txpwr_seq_tb;
    localparam int T_IO = 3, T_BG = 4, T_PLL = 6, POLL = 2, POLL_MAX = 8;
    localparam int NPOLL = POLL_MAX / POLL;
    localparam logic [7:0] R_LVDS = 8'h00, R_DP = 8'h06;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start_i = 1'b0, lvds_sel_i = 1'b0, tick_us_i = 1'b0, dpd_busy_i = 1'b0;
    logic port_pd_o, pll_pd_o, bgap_pd_o, vco_pd_o, loopcap_pd_o, io_dpd_o, cal_pd_o;
    logic [7:0] link_rate_o;
    logic pwr_ready_o, dpd_err_o;

    int vectors = 0, miscompares = 0;
    int phase, pt, wt, np;
    logic m_err;
    logic [7:0] m_rate;

    always #5 clk = ~clk;

    txpwr_seq #(.T_IO_US(T_IO), .T_BG_US(T_BG), .T_PLL_US(T_PLL),
                .POLL_US(POLL), .POLL_MAX_US(POLL_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .lvds_sel_i(lvds_sel_i),
        .tick_us_i(tick_us_i), .dpd_busy_i(dpd_busy_i),
        .port_pd_o(port_pd_o), .pll_pd_o(pll_pd_o), .bgap_pd_o(bgap_pd_o),
        .vco_pd_o(vco_pd_o), .loopcap_pd_o(loopcap_pd_o), .io_dpd_o(io_dpd_o),
        .cal_pd_o(cal_pd_o), .link_rate_o(link_rate_o),
        .pwr_ready_o(pwr_ready_o), .dpd_err_o(dpd_err_o));

    function automatic logic [6:0] exp_ctrl(int ph);
        case (ph)
            2, 3:    return 7'b1111101;
            4:       return 7'b1101101;
            5:       return 7'b1000001;
            6:       return 7'b0000001;
            default: return 7'b1111111;
        endcase
    endfunction

    function automatic string req_of(int ph);
        case (ph)
            0: return "R10";
            1: return "R3";
            2: return "R4";
            3: return "R6";
            4: return "R7";
            5: return "R8";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all();
        chk(req_of(phase), {25'd0, port_pd_o, pll_pd_o, bgap_pd_o, vco_pd_o,
                            loopcap_pd_o, io_dpd_o, cal_pd_o}, {25'd0, exp_ctrl(phase)});
        chk("R9", {31'd0, cal_pd_o}, 32'd1);
        chk("R2", {24'd0, link_rate_o}, {24'd0, m_rate});
        chk("R8", {31'd0, pwr_ready_o}, {31'd0, phase == 6});
        chk("R5", {31'd0, dpd_err_o}, {31'd0, m_err});
    endtask

    task automatic model_tick(logic busy);
        case (phase)
            2: begin
                pt++;
                if (pt == POLL) begin
                    pt = 0;
                    if (!busy) phase = 3;
                    else begin
                        np++;
                        if (np == NPOLL) begin m_err = 1'b1; phase = 3; end
                    end
                end
            end
            3: begin wt++; if (wt == T_IO)  begin wt = 0; phase = 4; end end
            4: begin wt++; if (wt == T_BG)  begin wt = 0; phase = 5; end end
            5: begin wt++; if (wt == T_PLL) begin wt = 0; phase = 6; end end
            default: ;
        endcase
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; start_i = 1'b0; tick_us_i = 1'b0; dpd_busy_i = 1'b0;
        phase = 0; pt = 0; wt = 0; np = 0; m_err = 1'b0; m_rate = R_DP;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all(); // R1 reset state
    endtask

    // One tick with optional stray start and mode flip, then random idle gap.
    task automatic one_tick(int busy_polls, logic stray);
        logic busy;
        busy = (np < busy_polls);
        dpd_busy_i = busy;
        tick_us_i = 1'b1;
        if (stray) begin
            start_i = ($urandom_range(0, 3) == 0);
            lvds_sel_i = $urandom_range(0, 1);
        end
        @(negedge clk);
        tick_us_i = 1'b0; start_i = 1'b0;
        model_tick(busy);
        repeat ($urandom_range(0, 3)) @(negedge clk);
        check_all();
    endtask

    task automatic run_seq(logic lvds, int busy_polls);
        lvds_sel_i = lvds;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        phase = 1;
        m_rate = lvds ? R_LVDS : R_DP;
        check_all(); // R3 step one, R2 rate latched
        @(negedge clk);
        phase = 2;
        check_all(); // R3 pad control released
        while (phase != 6) one_tick(busy_polls, 1'b1);
        repeat (3) one_tick(busy_polls, 1'b0);
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R10: ticks in IDLE change nothing
        repeat (3) one_tick(0, 1'b0);
        run_seq(1'b0, 0);
        // R10: start after ready is ignored
        lvds_sel_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        check_all();
        // R11: reset clears ready
        do_reset();
        run_seq(1'b1, 2);
        do_reset();
        run_seq(1'b0, 9); // R5 poll budget exhausted
        do_reset();
        run_seq(1'b1, NPOLL - 1); // R5 boundary: answer on last poll
        for (int i = 0; i < 5; i++) begin
            do_reset();
            run_seq($urandom_range(0, 1), $urandom_range(0, 5));
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL R8 actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule